// File: doc/BRIEF.md
# Memory Region Access Classifier

This block sorts every processor load or store by where its address lands. It reports whether the access is a cacheable DRAM access, an uncached DRAM access, an access forwarded to the PCI side, a load that must return zero, a store that must be dropped, or an address that no region claims. Two writable limit registers place the top of DRAM and the start of an uncached window at the top of DRAM. A two-bit aperture mode controls how the lowest 256 bytes and the PCI range above DRAM behave.

Accesses arrive on a valid/ready stream and leave with their classification in the same cycle. The block adds no latency and holds no data. `acc_ready` follows `cls_ready`, and `cls_valid` follows `acc_valid`. Back-pressure therefore passes straight through. While an access waits with `cls_ready` low, the upstream side must hold `acc_addr` and `acc_store` steady. The classification then stays steady as well, unless a register write lands at the same time. The register write port is a plain single-cycle strobe.

Top module: `region_classifier`

## Requirements
- R1: After reset the aperture mode is 00, the DRAM limit equals `DLIM_RST`, and the uncached-window start equals the same value. No DRAM address is uncached and `cfg_err` is 0.
- R2: `cls_cacheable` is 1 for a valid access with `DRAM_BASE <= addr < window_start` and `addr < dram_limit`.
- R3: `cls_uncached` is 1 for a valid access with `max(DRAM_BASE, window_start) <= addr < dram_limit`. It is never 1 together with `cls_cacheable`.
- R4: A write to select 1 (DRAM limit) or select 2 (window start) stores `wr_data` with its low `GRAN_BITS` (default 16) bits cleared. Limits therefore move in 64 KB steps.
- R5: In mode 00, a load below 0x100 sets `cls_zero` and not `cls_pci`. A store below 0x100 sets `cls_pci`.
- R6: In modes 00, 01 and 11, an access with `dram_limit <= addr < PCI_END` sets `cls_pci`.
- R7: In mode 01, loads and stores below 0x100 set `cls_pci`, and `cls_zero` stays 0.
- R8: In mode 10, `cls_pci` is never set. Loads below 0x100 or in the PCI range set `cls_zero`, and stores there set `cls_drop`.
- R9: In mode 11, accesses are classified as in mode 00, and `cfg_err` is 1 for as long as the mode register holds 11.
- R10: `cls_decerr` is 1 for a valid access that is not below 0x100, not in DRAM and not in the PCI range. No other access flag is set with it.
- R11: `cls_valid` equals `acc_valid` and `acc_ready` equals `cls_ready`. Every access flag is 0 while `acc_valid` is 0.
- R12: A write to select 3 changes no register. A mode write uses only `wr_data[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 mode, 1 DRAM limit, 2 window start, 3 unused |
| wr_data | input | ADDR_W | Write data |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Access accepted (follows cls_ready) |
| acc_addr | input | ADDR_W | Access address |
| acc_store | input | 1 | 1 store, 0 load |
| cls_valid | output | 1 | Classification present |
| cls_ready | input | 1 | Downstream accepts classification |
| cls_cacheable | output | 1 | Cacheable DRAM access |
| cls_uncached | output | 1 | DRAM access in the uncached window |
| cls_pci | output | 1 | Forward to PCI |
| cls_zero | output | 1 | Load returns zero, no bus read |
| cls_drop | output | 1 | Store has no effect |
| cls_decerr | output | 1 | Address maps to no region |
| cfg_err | output | 1 | Mode register holds the reserved code |

## Verification
Addresses are placed on each side of every boundary: 0xFF and 0x100, `DRAM_BASE`, the window start, the DRAM limit, and `PCI_END`. This separates off-by-one errors in each comparison. Each boundary is tried with both a load and a store under all four modes. That tells the hole, pass-through, disabled and reserved behaviours apart, since they differ only in the load/store split. The limits are moved with unaligned data, and select 3 is written with garbage, to show granularity masking and write isolation. The valid and ready inputs are toggled independently to confirm pure pass-through.

// File: rtl/region_pkg.sv
package region_pkg;
  typedef enum logic [1:0] {
    AP_HOLE = 2'b00,
    AP_PASS = 2'b01,
    AP_OFF  = 2'b10,
    AP_RSVD = 2'b11
  } ap_mode_e;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_DLIM = 2'd1;
  localparam logic [1:0] SEL_CLIM = 2'd2;
endpackage

// File: rtl/rc_cfg_regs.sv
module rc_cfg_regs
  import region_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          GRAN_BITS = 16,
  parameter logic [31:0] DLIM_RST  = 32'h1100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output ap_mode_e          mode,
  output logic [ADDR_W-1:0] dram_lim,
  output logic [ADDR_W-1:0] cache_lim
);
  localparam logic [ADDR_W-1:0] LIM_MASK  = {ADDR_W{1'b1}} << GRAN_BITS;
  localparam logic [ADDR_W-1:0] RST_LIMIT = DLIM_RST[ADDR_W-1:0] & LIM_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= AP_HOLE;
      dram_lim  <= RST_LIMIT;
      cache_lim <= RST_LIMIT;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MODE: mode      <= ap_mode_e'(wr_data[1:0]);
        SEL_DLIM: dram_lim  <= wr_data & LIM_MASK;
        SEL_CLIM: cache_lim <= wr_data & LIM_MASK;
        default:  ;
      endcase
    end
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cache_lim == dram_lim) && (mode == AP_HOLE));

  // R4
  clim_gran_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CLIM) |=> cache_lim == ($past(wr_data) & LIM_MASK));

  // R12
  spare_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> $stable(mode) && $stable(dram_lim) && $stable(cache_lim));
endmodule

// File: rtl/rc_window_dec.sv
module rc_window_dec #(
  parameter int          ADDR_W    = 32,
  parameter int          HOLE_BITS = 8,
  parameter logic [31:0] DRAM_BASE = 32'h1000_0000,
  parameter logic [31:0] PCI_END   = 32'h8000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] dram_lim,
  input  logic [ADDR_W-1:0] cache_lim,
  output logic              low_hit,
  output logic              dram_hit,
  output logic              pci_hit,
  output logic              cached,
  output logic              uncached
);
  localparam logic [ADDR_W-1:0] HOLE_TOP = ADDR_W'(1) << HOLE_BITS;
  localparam logic [ADDR_W-1:0] D_BASE   = DRAM_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] P_END    = PCI_END[ADDR_W-1:0];

  logic below_win;

  always_comb begin
    low_hit   = addr < HOLE_TOP;
    dram_hit  = (addr >= D_BASE) && (addr < dram_lim);
    pci_hit   = !dram_hit && (addr >= dram_lim) && (addr < P_END);
    below_win = addr < cache_lim;
    cached    = dram_hit && below_win;
    uncached  = dram_hit && !below_win;
  end
endmodule

// File: rtl/rc_aperture_dec.sv
module rc_aperture_dec
  import region_pkg::*;
(
  input  ap_mode_e mode,
  input  logic     is_store,
  input  logic     low_hit,
  input  logic     pci_hit,
  output logic     to_pci,
  output logic     ret_zero,
  output logic     kill_store,
  output logic     bad_mode
);
  ap_mode_e eff;

  always_comb begin
    bad_mode   = (mode == AP_RSVD);
    eff        = bad_mode ? AP_HOLE : mode;
    to_pci     = 1'b0;
    ret_zero   = 1'b0;
    kill_store = 1'b0;
    case (eff)
      AP_PASS: to_pci = pci_hit || low_hit;
      AP_OFF: begin
        ret_zero   = !is_store && (pci_hit || low_hit);
        kill_store = is_store && (pci_hit || low_hit);
      end
      default: begin
        to_pci   = pci_hit || (low_hit && is_store);
        ret_zero = low_hit && !is_store;
      end
    endcase
  end
endmodule

// File: rtl/region_classifier.sv
module region_classifier
  import region_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          GRAN_BITS = 16,
  parameter int          HOLE_BITS = 8,
  parameter logic [31:0] DRAM_BASE = 32'h1000_0000,
  parameter logic [31:0] DLIM_RST  = 32'h1100_0000,
  parameter logic [31:0] PCI_END   = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  output logic              cls_valid,
  input  logic              cls_ready,
  output logic              cls_cacheable,
  output logic              cls_uncached,
  output logic              cls_pci,
  output logic              cls_zero,
  output logic              cls_drop,
  output logic              cls_decerr,
  output logic              cfg_err
);
  ap_mode_e          mode;
  logic [ADDR_W-1:0] dram_lim, cache_lim;
  logic low_hit, dram_hit, pci_hit, cached, uncached;
  logic to_pci, ret_zero, kill_store;

  rc_cfg_regs #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .DLIM_RST(DLIM_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode(mode), .dram_lim(dram_lim), .cache_lim(cache_lim)
  );

  rc_window_dec #(.ADDR_W(ADDR_W), .HOLE_BITS(HOLE_BITS), .DRAM_BASE(DRAM_BASE),
                  .PCI_END(PCI_END)) u_win (
    .addr(acc_addr), .dram_lim(dram_lim), .cache_lim(cache_lim),
    .low_hit(low_hit), .dram_hit(dram_hit), .pci_hit(pci_hit),
    .cached(cached), .uncached(uncached)
  );

  rc_aperture_dec u_ap (
    .mode(mode), .is_store(acc_store), .low_hit(low_hit), .pci_hit(pci_hit),
    .to_pci(to_pci), .ret_zero(ret_zero), .kill_store(kill_store), .bad_mode(cfg_err)
  );

  always_comb begin
    cls_valid     = acc_valid;
    acc_ready     = cls_ready;
    cls_cacheable = acc_valid && cached;
    cls_uncached  = acc_valid && uncached;
    cls_pci       = acc_valid && to_pci;
    cls_zero      = acc_valid && ret_zero;
    cls_drop      = acc_valid && kill_store;
    cls_decerr    = acc_valid && !low_hit && !dram_hit && !pci_hit;
  end

  // R3
  cache_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cls_cacheable && cls_uncached));

  // R10
  decerr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_decerr |-> !(cls_pci || cls_zero || cls_drop || cls_cacheable || cls_uncached));

  // R8
  off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AP_OFF) |-> !cls_pci);

  // R9
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !cls_drop);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(cls_cacheable || cls_uncached || cls_pci || cls_zero || cls_drop || cls_decerr));
endmodule

// File: tb/region_classifier_tb.sv
module region_classifier_tb;
  localparam logic [31:0] DB  = 32'h1000_0000;
  localparam logic [31:0] DLR = 32'h1100_0000;
  localparam logic [31:0] PE  = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic acc_valid = 1'b0, acc_store = 1'b0, cls_ready = 1'b0;
  logic [31:0] acc_addr = '0;
  logic acc_ready, cls_valid, cls_cacheable, cls_uncached, cls_pci, cls_zero;
  logic cls_drop, cls_decerr, cfg_err;

  int total = 0;
  int bad = 0;
  logic [1:0]  m_mode = 2'd0;
  logic [31:0] m_dl = DLR;
  logic [31:0] m_cl = DLR;

  always #4 clk = ~clk;

  region_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_store(acc_store),
    .cls_valid(cls_valid), .cls_ready(cls_ready), .cls_cacheable(cls_cacheable),
    .cls_uncached(cls_uncached), .cls_pci(cls_pci), .cls_zero(cls_zero),
    .cls_drop(cls_drop), .cls_decerr(cls_decerr), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", tag, nm, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit v, input bit st, input logic [31:0] a,
                      input bit rdy, input bit we, input logic [1:0] ws, input logic [31:0] wd);
    bit lowr, dram, pcir;
    logic [1:0] eff;
    @(negedge clk);
    acc_valid = v; acc_store = st; acc_addr = a; cls_ready = rdy;
    wr_en = we; wr_sel = ws; wr_data = wd;
    #1;
    lowr = a < 32'h100;
    dram = (a >= DB) && (a < m_dl);
    pcir = !dram && (a >= m_dl) && (a < PE);
    eff  = (m_mode == 2'd3) ? 2'd0 : m_mode;
    chk(tag, "cls_valid R11", cls_valid, v);
    chk(tag, "acc_ready R11", acc_ready, rdy);
    chk(tag, "cacheable R2", cls_cacheable, v && dram && (a < m_cl));
    chk(tag, "uncached R3", cls_uncached, v && dram && (a >= m_cl));
    chk(tag, "pci R6", cls_pci, v && (eff != 2'd2) && (pcir || (lowr && (st || eff == 2'd1))));
    chk(tag, "zero R5", cls_zero, v && !st && ((eff == 2'd0 && lowr) || (eff == 2'd2 && (lowr || pcir))));
    chk(tag, "drop R8", cls_drop, v && st && eff == 2'd2 && (lowr || pcir));
    chk(tag, "decerr R10", cls_decerr, v && !lowr && !dram && !pcir);
    chk(tag, "cfg_err R9", cfg_err, m_mode == 2'd3);
    @(posedge clk);
    if (we) begin
      case (ws)
        2'd0: m_mode = wd[1:0];
        2'd1: m_dl = {wd[31:16], 16'h0};
        2'd2: m_cl = {wd[31:16], 16'h0};
        default: ;
      endcase
    end
  endtask

  task automatic acc(input string tag, input bit st, input logic [31:0] a);
    step(tag, 1'b1, st, a, 1'b1, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic wr(input string tag, input logic [1:0] ws, input logic [31:0] wd);
    step(tag, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, ws, wd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state: empty window, mode 00
    acc("R1", 1'b0, DLR - 32'h4);
    acc("R1", 1'b0, DB + 32'h10);
    acc("R2", 1'b1, DB);
    acc("R10", 1'b0, DB - 32'h1);
    // R5 hole in mode 00
    acc("R5", 1'b0, 32'h0);
    acc("R5", 1'b0, 32'hFF);
    acc("R5", 1'b1, 32'h40);
    acc("R10", 1'b0, 32'h100);
    // R6 PCI range
    acc("R6", 1'b0, DLR);
    acc("R6", 1'b1, PE - 32'h1);
    acc("R10", 1'b1, PE);
    // R4 unaligned window start
    wr("R4", 2'd2, 32'h10FF_1234);
    acc("R4", 1'b0, 32'h10FE_FFFF);
    acc("R3", 1'b0, 32'h10FF_0000);
    acc("R3", 1'b1, DLR - 32'h1);
    // R4 raise DRAM limit with unaligned data
    wr("R4", 2'd1, 32'h1200_ABCD);
    acc("R3", 1'b0, DLR);
    acc("R6", 1'b0, 32'h1200_0000);
    // R12 spare select and high mode bits
    wr("R12", 2'd3, 32'hFFFF_FFFF);
    acc("R12", 1'b0, 32'h10FF_0000);
    acc("R12", 1'b0, 32'h20);
    wr("R12", 2'd0, 32'hFFFF_FFF1);
    // R7 pass mode
    acc("R7", 1'b0, 32'h0);
    acc("R7", 1'b1, 32'hFF);
    acc("R7", 1'b0, 32'h1300_0000);
    // R8 apertures off
    wr("R8", 2'd0, 32'h2);
    acc("R8", 1'b0, 32'h10);
    acc("R8", 1'b1, 32'h10);
    acc("R8", 1'b0, 32'h4000_0000);
    acc("R8", 1'b1, 32'h4000_0000);
    acc("R8", 1'b0, DB);
    // R9 reserved mode
    wr("R9", 2'd0, 32'h3);
    acc("R9", 1'b0, 32'h8);
    acc("R9", 1'b1, 32'h8);
    acc("R9", 1'b0, 32'h5000_0000);
    // R11 handshake pass-through and idle quiet
    step("R11", 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd0, 32'h0);
    step("R11", 1'b1, 1'b0, DB, 1'b0, 1'b0, 2'd0, 32'h0);
    step("R11", 1'b0, 1'b1, 32'h4000_0000, 1'b0, 1'b0, 2'd0, 32'h0);
    // window start below DRAM base: whole DRAM uncached (R3)
    wr("R3", 2'd2, 32'h0800_0000);
    acc("R3", 1'b0, DB);
    // sweep across all modes and boundary addresses
    for (int m = 0; m < 4; m++) begin
      wr("R6", 2'd0, 32'(m));
      for (int k = 0; k < 10; k++) begin
        logic [31:0] a;
        case (k)
          0: a = 32'hFF; 1: a = 32'h100; 2: a = DB - 1; 3: a = DB;
          4: a = 32'h11FF_FFFF; 5: a = 32'h1200_0000; 6: a = PE - 1;
          7: a = PE; 8: a = 32'h0; default: a = 32'hFFFF_FFFF;
        endcase
        acc("R6", 1'b0, a);
        acc("R8", 1'b1, a);
      end
    end
    // reset again restores R1 state
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk);
    m_mode = 2'd0; m_dl = DLR; m_cl = DLR;
    @(negedge clk); rst_n = 1'b1;
    acc("R1", 1'b0, DLR - 32'h1);
    acc("R1", 1'b0, 32'h4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule